// File: doc/BRIEF.md
# Operand-Isolated 8-bit Arithmetic and Logic Unit

This block computes one of eight operations on two 8-bit operands and returns an 8-bit result with carry, borrow and zero flags. It contains four separate functional units: a bitwise logic unit (NAND, NOR, XOR), an adder/subtractor built from replicated 1-bit slices, a logical left barrel shifter and an 8x8 array multiplier. A single eight-way result multiplexer, steered by the 3-bit operation code, picks the final result.

The operation code is also decoded into one enable per unit. Each enable gates that unit's operand pair. Every unit that is not selected sees all-zero inputs, so it does not toggle. The multiplier always forms the full 16-bit product. Two codes share it: one returns the low byte and the other returns the high byte. Result and flags are captured in one output register stage that has a synchronous active-low reset.

Top module: `alu8_isolated`

## Requirements
- R1: Code 000 gives ~(A&B), code 001 gives ~(A|B) and code 010 gives A^B.
- R2: Code 101 gives (A+B) mod 256, and carry_o is bit 8 of the 9-bit sum.
- R3: Code 011 gives (A-B) mod 256, computed as A+~B+1. borrow_o is 1 exactly when A < B as unsigned values.
- R4: Code 100 gives A shifted left by B[2:0] with zero fill. B[7:3] has no effect on the result.
- R5: Code 110 gives bits 7..0 of the unsigned 16-bit product A*B, and code 111 gives bits 15..8.
- R6: carry_o is 0 for every code other than 101, and borrow_o is 0 for every code other than 011.
- R7: zero_o is 1 exactly when the 8-bit result is zero, for every operation.
- R8: The operands of each functional unit that the current code does not select are held at zero, and only the selected unit's output reaches result_o.
- R9: Outputs are registered with one cycle of latency. While rst_n is low at a rising edge, result_o, carry_o, borrow_o and zero_o all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand, or shift amount in bits 2..0 |
| result_o | output | 8 | Registered result |
| carry_o | output | 1 | Carry out of addition |
| borrow_o | output | 1 | Borrow of subtraction |
| zero_o | output | 1 | Result equals zero |

## Verification
The hardest case to reach from the ports is a leak from an idle unit: a gated operand pair that is not fully zero, or a mux input that reaches the result under the wrong code. From outside, such a leak looks like a correct result with a glitch. The stimulus therefore changes the code every cycle while the operands stay at all-ones and other extreme values, so a leaking unit would carry large values. In-module assertions check the gated operands directly against the code. The high product byte and the borrow are driven with 255x255, 255-1 and 0-1 so that the top carries and the wrap-around are exercised.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W  = 8;
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int UNITS   = 4;

    // Unit indices into the enable vector
    localparam int U_LOGIC = 0;
    localparam int U_ARITH = 1;
    localparam int U_SHIFT = 2;
    localparam int U_MUL   = 3;

    typedef enum logic [2:0] {
        OP_NAND  = 3'b000,
        OP_NOR   = 3'b001,
        OP_XOR   = 3'b010,
        OP_SUB   = 3'b011,
        OP_SHL   = 3'b100,
        OP_ADD   = 3'b101,
        OP_MULLO = 3'b110,
        OP_MULHI = 3'b111
    } alu_op_e;
endpackage

// File: rtl/alu8_isolate.sv
// Operand isolation: decodes the operation code into one enable per
// functional unit and forces the operands of every idle unit to zero.
// Assumes codes follow alu_op_e; exactly one unit is enabled per code.
module alu8_isolate #(
    parameter int W = alu8_pkg::DATA_W,
    parameter int N = alu8_pkg::UNITS
) (
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [N-1:0] en_o,
    output logic [W-1:0] ga_o [N],
    output logic [W-1:0] gb_o [N]
);
    import alu8_pkg::*;

    // Map each code to the unit that serves it
    always_comb begin
        en_o = '0;
        case (alu_op_e'(op_i))
            OP_NAND, OP_NOR, OP_XOR: en_o[U_LOGIC] = 1'b1;
            OP_SUB, OP_ADD:          en_o[U_ARITH] = 1'b1;
            OP_SHL:                  en_o[U_SHIFT] = 1'b1;
            default:                 en_o[U_MUL]   = 1'b1;
        endcase
    end

    // AND-gate each unit's operand pair with its enable
    for (genvar u = 0; u < N; u++) begin : g_gate
        assign ga_o[u] = a_i & {W{en_o[u]}};
        assign gb_o[u] = b_i & {W{en_o[u]}};
    end
endmodule

// File: rtl/alu8_slice.sv
// One-bit slice: bitwise logic on one operand pair and a full adder on
// a second, independently gated operand pair. Replicated W times.
module alu8_slice (
    input  logic la,
    input  logic lb,
    input  logic aa,
    input  logic ab,
    input  logic cin,
    output logic nand_o,
    output logic nor_o,
    output logic xor_o,
    output logic sum_o,
    output logic cout_o
);
    logic p;

    // Logic functions and full-adder sum/carry for this bit
    always_comb begin
        nand_o = ~(la & lb);
        nor_o  = ~(la | lb);
        xor_o  = la ^ lb;
        p      = aa ^ ab;
        sum_o  = p ^ cin;
        cout_o = (aa & ab) | (p & cin);
    end
endmodule

// File: rtl/alu8_shifter.sv
// Logical left barrel shifter, log2(W) stages, zero fill.
// Assumes only the low SHW bits of the amount are meaningful.
module alu8_shifter #(
    parameter int W   = alu8_pkg::DATA_W,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   d_i,
    input  logic [SHW-1:0] amt_i,
    output logic [W-1:0]   q_o
);
    logic [W-1:0] stage [SHW+1];

    assign stage[0] = d_i;
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        // Shift by 2^s when amount bit s is set
        assign stage[s+1] = amt_i[s] ? (stage[s] << (1 << s)) : stage[s];
    end
    assign q_o = stage[SHW];
endmodule

// File: rtl/alu8_mult.sv
// Unsigned W x W array multiplier giving the full 2W-bit product.
// Partial products are formed in a generate loop and summed.
module alu8_mult #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] p_o
);
    logic [2*W-1:0] pp [W];

    for (genvar i = 0; i < W; i++) begin : g_pp
        assign pp[i] = {{W{1'b0}}, (a_i & {W{b_i[i]}})} << i;
    end

    // Accumulate the shifted partial products
    always_comb begin
        p_o = '0;
        for (int i = 0; i < W; i++) p_o = p_o + pp[i];
    end
endmodule

// File: rtl/alu8_isolated.sv
// Top: operand-isolated ALU. The four units get gated operands, an
// eight-way mux picks the result and flags, and one register stage
// with synchronous active-low reset holds the outputs.
module alu8_isolated #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] result_o,
    output logic         carry_o,
    output logic         borrow_o,
    output logic         zero_o
);
    import alu8_pkg::*;
    localparam int SHW = $clog2(W);

    logic [UNITS-1:0] en;
    logic [W-1:0]     ga [UNITS];
    logic [W-1:0]     gb [UNITS];

    alu8_isolate #(.W(W), .N(UNITS)) u_iso (
        .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .en_o(en), .ga_o(ga), .gb_o(gb)
    );

    // Subtract flag is qualified by the arith enable so an idle unit stays at zero
    logic         sub;
    logic [W-1:0] ab_eff;
    logic [W:0]   carry;
    logic [W-1:0] nand_v, nor_v, xor_v, sum_v;

    assign sub      = en[U_ARITH] & (op_i == OP_SUB);
    assign ab_eff   = gb[U_ARITH] ^ {W{sub}};
    assign carry[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu8_slice u_slice (
            .la(ga[U_LOGIC][i]), .lb(gb[U_LOGIC][i]),
            .aa(ga[U_ARITH][i]), .ab(ab_eff[i]),
            .cin(carry[i]),
            .nand_o(nand_v[i]), .nor_o(nor_v[i]), .xor_o(xor_v[i]),
            .sum_o(sum_v[i]), .cout_o(carry[i+1])
        );
    end

    logic [W-1:0]   shl_v;
    logic [W-1:SHW] shamt_hi_unused;
    assign shamt_hi_unused = gb[U_SHIFT][W-1:SHW];

    alu8_shifter #(.W(W), .SHW(SHW)) u_shl (
        .d_i(ga[U_SHIFT]), .amt_i(gb[U_SHIFT][SHW-1:0]), .q_o(shl_v)
    );

    logic [2*W-1:0] prod;
    alu8_mult #(.W(W)) u_mul (.a_i(ga[U_MUL]), .b_i(gb[U_MUL]), .p_o(prod));

    // Eight-way result multiplexer and flag selection
    logic [W-1:0] res_d;
    logic         cy_d, bw_d;
    always_comb begin
        cy_d = 1'b0;
        bw_d = 1'b0;
        case (alu_op_e'(op_i))
            OP_NAND:  res_d = nand_v;
            OP_NOR:   res_d = nor_v;
            OP_XOR:   res_d = xor_v;
            OP_SUB:   begin res_d = sum_v; bw_d = ~carry[W]; end
            OP_SHL:   res_d = shl_v;
            OP_ADD:   begin res_d = sum_v; cy_d = carry[W]; end
            OP_MULLO: res_d = prod[W-1:0];
            default:  res_d = prod[2*W-1:W];
        endcase
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
            borrow_o <= 1'b0;
            zero_o   <= 1'b0;
        end else begin
            result_o <= res_d;
            carry_o  <= cy_d;
            borrow_o <= bw_d;
            zero_o   <= (res_d == '0);
        end
    end

    // Isolation: idle units see zero operands
    assert_mul_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_MULLO && op_i != OP_MULHI) |-> (ga[U_MUL] == '0 && gb[U_MUL] == '0));
    assert_arith_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_ADD && op_i != OP_SUB) |-> (ga[U_ARITH] == '0 && ab_eff == '0));
    assert_shift_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_SHL) |-> (ga[U_SHIFT] == '0 && gb[U_SHIFT] == '0));
    assert_logic_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OP_XOR) |-> (ga[U_LOGIC] == '0 && gb[U_LOGIC] == '0));
    // Flags only on their own operation
    assert_carry_only_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_ADD) |=> !carry_o);
    assert_borrow_only_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_SUB) |=> !borrow_o);
    // Zero flag tracks the registered result
    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (zero_o == (result_o == '0)));
    // Reset clears every output
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !carry_o && !borrow_o && !zero_o));
endmodule

// File: tb/alu8_isolated_tb.sv
module alu8_isolated_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op = '0;
    logic [7:0] a = '0, b = '0;
    logic [7:0] result;
    logic       carry, borrow, zero;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] op;
        logic [7:0] a, b, res;
        logic       cy, bw, z;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    alu8_isolated u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .result_o(result), .carry_o(carry), .borrow_o(borrow), .zero_o(zero)
    );

    function automatic string req_of(logic [2:0] o);
        case (o)
            3'd0, 3'd1, 3'd2: return "R1";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R2";
            default: return "R5";
        endcase
    endfunction

    function automatic exp_t model(logic [2:0] o, logic [7:0] x, logic [7:0] y);
        exp_t e;
        logic [15:0] p;
        logic [8:0]  s;
        e.op = o; e.a = x; e.b = y; e.cy = 0; e.bw = 0;
        p = 16'(x) * 16'(y);
        case (o)
            3'd0: e.res = ~(x & y);
            3'd1: e.res = ~(x | y);
            3'd2: e.res = x ^ y;
            3'd3: begin e.res = x - y; e.bw = (x < y); end
            3'd4: e.res = x << y[2:0];
            3'd5: begin s = {1'b0, x} + {1'b0, y}; e.res = s[7:0]; e.cy = s[8]; end
            3'd6: e.res = p[7:0];
            default: e.res = p[15:8];
        endcase
        e.z = (e.res == 8'd0);
        return e;
    endfunction

    task automatic chk(string r, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    // Driver: apply one operation at the falling edge and queue its expectation
    task automatic drive(logic [2:0] o, logic [7:0] x, logic [7:0] y);
        @(negedge clk);
        op = o; a = x; b = y;
        q.push_back(model(o, x, y));
    endtask

    // Monitor: after each rising edge compare the registered outputs
    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(req_of(e.op), $sformatf("R8 result op=%0d a=%0h b=%0h", e.op, e.a, e.b), result, e.res);
            chk(e.op == 3'd5 ? "R2" : "R6", "carry", carry, e.cy);
            chk(e.op == 3'd3 ? "R3" : "R6", "borrow", borrow, e.bw);
            chk("R7", "zero", zero, e.z);
        end
    end

    initial begin
        #(10 * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [7:0] corner [8] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h7F, 8'h0F, 8'hAA, 8'h55};

    initial begin
        // R9: reset clears outputs even with live, nonzero inputs
        op = 3'd5; a = 8'hFF; b = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset result", result, 0);
        chk("R9", "reset carry", carry, 0);
        chk("R9", "reset borrow", borrow, 0);
        chk("R9", "reset zero", zero, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Corner operand pairs, code changing every cycle (R8 leak hunt)
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                for (int o = 0; o < 8; o++)
                    drive(3'(o), corner[i], corner[j]);

        // R4: upper amount bits ignored
        for (int s = 0; s < 32; s++) drive(3'd4, 8'hB7, 8'(s * 8 + (s % 8)));
        // R5: largest product, both bytes
        drive(3'd6, 8'hFF, 8'hFF);
        drive(3'd7, 8'hFF, 8'hFF);
        // R3: equal operands give zero with no borrow
        drive(3'd3, 8'h5A, 8'h5A);

        // Random mix
        for (int k = 0; k < 3000; k++)
            drive(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom));

        @(negedge clk);
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R9 pending=%0d expected=0", q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule